// File: doc/BRIEF.md
# SIMD Pixel Pack and Expand Unit

This block carries out five pixel-formatting operations on 64-bit operands for a partitioned-arithmetic datapath. Three of them narrow wider fixed-point lanes into pixels. Each of these scales the lanes by a left shift taken from a status word, drops a fixed number of fraction bits, and saturates the value to its target range. The other two widen or interleave bytes: one turns four bytes into 16-bit lanes, and one interleaves the bytes of two 32-bit words.

The surrounding pipeline supplies a 9-bit operation code, two 64-bit sources and the status word, and pulses a start strobe. One clock later the unit presents the registered 64-bit result with a valid strobe. Results that are 32 bits wide are zero-extended. An unsupported code produces a zero result and raises an illegal-code flag along with the valid strobe.

Top module: `pixfmt_unit`

## Requirements
- R1: Code 0x03B narrows each of the four signed 16-bit lanes i of source 2 (bits 16i+15..16i). The lane is shifted left by the scale in status bits 6..3, arithmetic-shifted right by 7 and clamped to 0..255, and the result goes to result byte i (bits 8i+7..8i). Status bit 7 has no effect, and result bits 63..32 are zero.
- R2: Code 0x03A narrows each signed 32-bit lane w of source 2. The lane is shifted left by the scale in status bits 7..3, arithmetic-shifted right by 23 and clamped to 0..255.
- R3: For code 0x03A, the result is source 1 shifted left by 8 with result bytes 0 and 4 forced to zero, and with the byte from lane w then placed in result bits 32w+7..32w.
- R4: Code 0x03D narrows each signed 32-bit lane w of source 2. The lane is shifted left by the scale in status bits 7..3, arithmetic-shifted right by 16 and saturated to -32768..32767, and the result goes to bits 16w+15..16w. Result bits 63..32 are zero.
- R5: Code 0x04D takes byte i of source 2 bits 31..0, places it in bits 16i+11..16i+4 of the result, and sets the other bits of that lane to zero.
- R6: Code 0x04B writes byte i of source 2 to result byte 2i and byte i of source 1 to result byte 2i+1, for i = 0..3.
- R7: Any other code gives a zero result with the illegal flag set. The five codes above give a clear illegal flag.
- R8: The valid strobe is high exactly in the cycle after a cycle with start high, and the illegal flag is high only while the valid strobe is high.
- R9: A synchronous active-low reset clears the result, the valid strobe and the illegal flag.
- R10: While start is low, the result register holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Launch one operation this cycle |
| op_i | input | 9 | Operation code |
| src1_i | input | 64 | First source operand |
| src2_i | input | 64 | Second source operand |
| stat_i | input | 32 | Status word carrying the scale field |
| valid_o | output | 1 | Result valid, one cycle after start |
| illegal_o | output | 1 | Unsupported code, valid with valid_o |
| result_o | output | 64 | Registered result |

## Verification
The assertions check the properties that hold on every cycle. These are the one-cycle valid timing, the illegal flag appearing only with a zero result and a valid strobe, the result holding while idle, the reset clearing, and the structural parts of each format: zero upper halves, zero nibbles in expanded lanes, the merged low byte, and the shifted bytes that pass through the 32-to-8 pack. The scaling and saturation arithmetic at every scale value, and the full 512-code legality map, can only be shown by the bench sweeps, which compare each result against values computed arithmetically.

// File: rtl/pixfmt_pkg.sv
// Shared constants for the pixel pack/expand unit: operand widths, the
// scale field location in the status word, and the five operation codes.
package pixfmt_pkg;
    localparam int DATA_W    = 64;
    localparam int HALF_W    = DATA_W / 2;
    localparam int OP_W      = 9;
    localparam int STAT_W    = 32;
    localparam int SCALE_LSB = 3;
    localparam int SCALE_W   = 5;

    localparam logic [OP_W-1:0] OP_PACK_H2B = 9'h03B; // 16-bit lanes -> bytes
    localparam logic [OP_W-1:0] OP_PACK_W2B = 9'h03A; // 32-bit lanes -> bytes, merged
    localparam logic [OP_W-1:0] OP_PACK_W2H = 9'h03D; // 32-bit lanes -> 16-bit
    localparam logic [OP_W-1:0] OP_EXPAND   = 9'h04D; // bytes -> 16-bit lanes
    localparam logic [OP_W-1:0] OP_MERGE    = 9'h04B; // byte interleave
endpackage

// File: rtl/pixfmt_sat_lane.sv
// One scale-shift-saturate lane. It sign-extends an IN_W lane to 64 bits,
// shifts it left by the scale, arithmetic-shifts it right by FRAC bits and
// clamps it to the signed or unsigned OUT_W range.
// Assumes IN_W + 31 < 64, so the left shift cannot wrap before the clamp.
module pixfmt_sat_lane #(
    parameter int IN_W       = 16,
    parameter int FRAC       = 7,
    parameter int OUT_W      = 8,
    parameter bit SIGNED_OUT = 1'b0,
    parameter int SCALE_W    = 5
) (
    input  logic [IN_W-1:0]    lane_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [OUT_W-1:0]   q_o
);
    localparam int EXT_W = 64;
    localparam logic signed [EXT_W-1:0] LO =
        SIGNED_OUT ? -(64'sd1 <<< (OUT_W - 1)) : 64'sd0;
    localparam logic signed [EXT_W-1:0] HI =
        SIGNED_OUT ? (64'sd1 <<< (OUT_W - 1)) - 64'sd1
                   : (64'sd1 <<< OUT_W) - 64'sd1;

    logic signed [EXT_W-1:0] ext, shl, fix;

    // Widen, scale, drop the fraction bits, then clamp to the output range.
    always_comb begin
        ext = {{(EXT_W-IN_W){lane_i[IN_W-1]}}, lane_i};
        shl = ext <<< scale_i;
        fix = shl >>> FRAC;
        if (fix < LO)
            q_o = LO[OUT_W-1:0];
        else if (fix > HI)
            q_o = HI[OUT_W-1:0];
        else
            q_o = fix[OUT_W-1:0];
    end
endmodule

// File: rtl/pixfmt_bytemix.sv
// Byte rearrangement for the two non-arithmetic formats. It builds the
// expand result (each byte becomes a 16-bit lane, shifted left by 4) and
// the merge result (bytes of the two low words interleaved, source 2 in
// the even slots). Both are purely combinational.
module pixfmt_bytemix #(
    parameter int NBYTES = 4
) (
    input  logic [8*NBYTES-1:0]  a_i,     // low word of source 1
    input  logic [8*NBYTES-1:0]  b_i,     // low word of source 2
    output logic [16*NBYTES-1:0] expand_o,
    output logic [16*NBYTES-1:0] merge_o
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        // Expand: zero nibble above and below each byte.
        assign expand_o[16*i +: 16] = {4'b0000, b_i[8*i +: 8], 4'b0000};
        // Merge: source 2 byte low, source 1 byte high.
        assign merge_o[16*i +: 16]  = {a_i[8*i +: 8], b_i[8*i +: 8]};
    end
endmodule

// File: rtl/pixfmt_unit.sv
// Pixel pack/expand unit top. It decodes a 9-bit code, selects one of the
// five formatting results and registers it with a one-cycle valid strobe.
// Assumes start_i is a single-cycle pulse per operation; unknown codes
// give a zero result and a set illegal flag.
module pixfmt_unit
    import pixfmt_pkg::*;
#(
    parameter int H_LANES = DATA_W / 16,
    parameter int W_LANES = DATA_W / 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] src1_i,
    input  logic [DATA_W-1:0] src2_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              valid_o,
    output logic              illegal_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int BYTE_MASK_W = 8;

    logic [SCALE_W-1:0] scale_wide, scale_narrow;
    logic [8*H_LANES-1:0]  h2b_bytes;
    logic [8*W_LANES-1:0]  w2b_bytes;
    logic [16*W_LANES-1:0] w2h_halves;
    logic [DATA_W-1:0]     w2b_result;
    logic [DATA_W-1:0]     expand_res, merge_res;
    logic [DATA_W-1:0]     next_result;
    logic                  next_illegal;

    // Scale fields: five bits for word packs, the low four for the half pack.
    assign scale_wide   = stat_i[SCALE_LSB +: SCALE_W];
    assign scale_narrow = {1'b0, stat_i[SCALE_LSB +: SCALE_W-1]};

    for (genvar i = 0; i < H_LANES; i++) begin : g_h2b
        pixfmt_sat_lane #(.IN_W(16), .FRAC(7), .OUT_W(8),
                          .SIGNED_OUT(1'b0), .SCALE_W(SCALE_W)) u_lane (
            .lane_i (src2_i[16*i +: 16]),
            .scale_i(scale_narrow),
            .q_o    (h2b_bytes[8*i +: 8])
        );
    end

    for (genvar w = 0; w < W_LANES; w++) begin : g_word
        pixfmt_sat_lane #(.IN_W(32), .FRAC(23), .OUT_W(8),
                          .SIGNED_OUT(1'b0), .SCALE_W(SCALE_W)) u_w2b (
            .lane_i (src2_i[32*w +: 32]),
            .scale_i(scale_wide),
            .q_o    (w2b_bytes[8*w +: 8])
        );
        pixfmt_sat_lane #(.IN_W(32), .FRAC(16), .OUT_W(16),
                          .SIGNED_OUT(1'b1), .SCALE_W(SCALE_W)) u_w2h (
            .lane_i (src2_i[32*w +: 32]),
            .scale_i(scale_wide),
            .q_o    (w2h_halves[16*w +: 16])
        );
        // Word pack: shifted source 1 in the upper bytes, packed byte in the low byte.
        assign w2b_result[32*w +: 32] =
            {src1_i[32*w +: 32-BYTE_MASK_W], w2b_bytes[8*w +: 8]};
    end

    pixfmt_bytemix #(.NBYTES(HALF_W/8)) u_mix (
        .a_i     (src1_i[HALF_W-1:0]),
        .b_i     (src2_i[HALF_W-1:0]),
        .expand_o(expand_res),
        .merge_o (merge_res)
    );

    // Select the result for the current code; unknown codes give zero and flag.
    always_comb begin
        next_illegal = 1'b0;
        case (op_i)
            OP_PACK_H2B: next_result = {{(DATA_W-8*H_LANES){1'b0}}, h2b_bytes};
            OP_PACK_W2B: next_result = w2b_result;
            OP_PACK_W2H: next_result = {{(DATA_W-16*W_LANES){1'b0}}, w2h_halves};
            OP_EXPAND:   next_result = expand_res;
            OP_MERGE:    next_result = merge_res;
            default: begin
                next_result  = '0;
                next_illegal = 1'b1;
            end
        endcase
    end

    // Output register: capture on start, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            valid_o   <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            valid_o   <= start_i;
            illegal_o <= start_i & next_illegal;
            if (start_i)
                result_o <= next_result;
        end
    end
endmodule

// File: rtl/pixfmt_unit_chk.sv
// Checker for pixfmt_unit: timing of valid and illegal, hold behaviour,
// reset clearing, and per-format structural properties of the result.
module pixfmt_unit_chk
    import pixfmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] src1_i,
    input logic [DATA_W-1:0] src2_i,
    input logic              valid_o,
    input logic              illegal_o,
    input logic [DATA_W-1:0] result_o
);
    // R8
    valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);
    // R8
    no_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o);
    // R8
    illegal_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> valid_o);
    // R7
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (result_o == '0));
    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o));
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !illegal_o && result_o == '0));
    // R1
    h2b_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == OP_PACK_H2B) |=> (result_o[63:32] == '0 && !illegal_o));
    // R3
    w2b_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == OP_PACK_W2B) |=>
        (result_o[31:8] == $past(src1_i[23:0]) && result_o[63:40] == $past(src1_i[55:32])));
    // R5
    expand_nibbles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == OP_EXPAND) |=> ((result_o & 64'hF00F_F00F_F00F_F00F) == '0));
    // R6
    merge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == OP_MERGE) |=>
        (result_o[7:0] == $past(src2_i[7:0]) && result_o[15:8] == $past(src1_i[7:0])));
endmodule

bind pixfmt_unit pixfmt_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .src1_i   (src1_i),
    .src2_i   (src2_i),
    .valid_o  (valid_o),
    .illegal_o(illegal_o),
    .result_o (result_o)
);

// File: tb/sim_pixfmt_unit.sv
// Sweeps every scale value for the three packs, random and corner operands
// for all formats, and all 512 codes for legality.
module sim_pixfmt_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [8:0]  op_i = '0;
    logic [63:0] src1_i = '0, src2_i = '0;
    logic [31:0] stat_i = '0;
    logic        valid_o, illegal_o;
    logic [63:0] result_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixfmt_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .src1_i(src1_i), .src2_i(src2_i), .stat_i(stat_i),
        .valid_o(valid_o), .illegal_o(illegal_o), .result_o(result_o)
    );

    function automatic longint clampv(longint v, longint lo, longint hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic logic [63:0] model(logic [8:0] op, logic [63:0] a,
                                          logic [63:0] b, logic [31:0] st);
        logic [63:0] r = '0;
        longint v;
        int sc;
        case (op)
            9'h03B: begin
                sc = int'(st[6:3]);
                for (int i = 0; i < 4; i++) begin
                    v = longint'($signed(b[16*i +: 16])) * (64'sd1 <<< sc);
                    v = clampv(v >>> 7, 0, 255);
                    r[8*i +: 8] = v[7:0];
                end
            end
            9'h03A: begin
                sc = int'(st[7:3]);
                r = (a << 8) & ~64'h0000_00FF_0000_00FF;
                for (int w = 0; w < 2; w++) begin
                    v = longint'($signed(b[32*w +: 32])) * (64'sd1 <<< sc);
                    v = clampv(v >>> 23, 0, 255);
                    r[32*w +: 8] = v[7:0];
                end
            end
            9'h03D: begin
                sc = int'(st[7:3]);
                for (int w = 0; w < 2; w++) begin
                    v = longint'($signed(b[32*w +: 32])) * (64'sd1 <<< sc);
                    v = clampv(v >>> 16, -32768, 32767);
                    r[16*w +: 16] = v[15:0];
                end
            end
            9'h04D: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'(b[8*i +: 8]) * 16'd16;
            9'h04B: for (int i = 0; i < 4; i++) begin
                r[16*i +: 8]     = b[8*i +: 8];
                r[16*i + 8 +: 8] = a[8*i +: 8];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic bit legal(logic [8:0] op);
        return op == 9'h03B || op == 9'h03A || op == 9'h03D ||
               op == 9'h04D || op == 9'h04B;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Launch one operation and compare the registered result one cycle on.
    task automatic run(string req, logic [8:0] op, logic [63:0] a,
                       logic [63:0] b, logic [31:0] st);
        @(negedge clk);
        op_i = op; src1_i = a; src2_i = b; stat_i = st; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(req, result_o, model(op, a, b, st));
        check("R8 valid", 64'(valid_o), 64'd1);
        check("R7 illegal", 64'(illegal_o), 64'(!legal(op)));
    endtask

    function automatic logic [63:0] corner(int k);
        case (k % 8)
            0: return 64'h0000_0000_0000_0000;
            1: return 64'h7FFF_8000_00FF_0100;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_7FFF_FFFF;
            4: return 64'h0000_7F80_0040_0001;
            5: return 64'h00FF_FF00_FF80_007F;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        logic [63:0] held;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 reset valid", 64'(valid_o), 64'd0);
        check("R9 reset illegal", 64'(illegal_o), 64'd0);
        check("R9 reset result", result_o, 64'd0);
        rst_n = 1'b1;

        // R1: every 4-bit scale, status bit 7 toggled to show it is ignored
        for (int s = 0; s < 16; s++)
            for (int k = 0; k < 12; k++)
                run("R1", 9'h03B, {$urandom, $urandom}, corner(k),
                    ($urandom & 32'hFFFF_FF07) | (32'(s) << 3) | (32'(k[0]) << 7));
        // R2, R3: every 5-bit scale
        for (int s = 0; s < 32; s++)
            for (int k = 0; k < 10; k++)
                run("R2 R3", 9'h03A, corner(k + 3), corner(k),
                    ($urandom & 32'hFFFF_FF07) | (32'(s) << 3));
        // R4
        for (int s = 0; s < 32; s++)
            for (int k = 0; k < 10; k++)
                run("R4", 9'h03D, {$urandom, $urandom}, corner(k),
                    ($urandom & 32'hFFFF_FF07) | (32'(s) << 3));
        // R5, R6
        for (int k = 0; k < 40; k++) begin
            run("R5", 9'h04D, corner(k + 1), corner(k), $urandom);
            run("R6", 9'h04B, corner(k + 2), corner(k), $urandom);
        end
        // R7: full code sweep
        for (int c = 0; c < 512; c++)
            run("R7", 9'(c), {$urandom, $urandom}, {$urandom, $urandom}, $urandom);

        // R8, R10: no start, inputs change, output holds and valid drops
        run("R6", 9'h04B, 64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00, 32'h0);
        held = result_o;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            op_i = 9'h03B; src1_i = {$urandom, $urandom}; src2_i = {$urandom, $urandom};
            stat_i = $urandom;
            check("R10 hold", result_o, held);
            check("R8 idle valid", 64'(valid_o), 64'd0);
        end

        // R9: mid-run reset clears an illegal result and a data result
        run("R7", 9'h1FF, '1, '1, '1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 valid", 64'(valid_o), 64'd0);
        check("R9 illegal", 64'(illegal_o), 64'd0);
        rst_n = 1'b1;
        run("R5", 9'h04D, '0, 64'hFFFF_FFFF, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 result", result_o, 64'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule